// File: doc/BRIEF.md
# Hardware Task Context Switch Sequencer

This block moves a processor from one task to another when the full register context of each task lives in a record in memory. A single-cycle request carries the selector of the task to switch to. The sequencer copies the live register context into the record of the running task. It then points the task register at the new selector and fetches that selector's entry in the global descriptor table to find the new record. If the entry is valid, it loads the new context into the register file and pulses done so that execution can resume. The five phases always run in that fixed order.

A record is a flat run of 32-bit words, one word per context field. The fields are the general registers, the segment registers, the flags word, the instruction pointer, a stack selector and a stack pointer for each of privilege levels 0, 1 and 2, the local descriptor table selector, and the page table base. Memory is reached through a word-wide read/write port that waits for an acknowledge on every access. The register file is reached through an indexed read path and a write strobe. If the descriptor does not describe a task record, the switch stops with a fault and the context is left as it was.

Top module: `task_switch_seq`

## Requirements
- R1: After reset, busy, done, fault, mem_req and ctx_wr_en are low, and tr_sel and tr_base hold the TR_RST_SEL and TR_RST_BASE parameter values.
- R2: A request accepted while idle first writes all 24 context fields to the record at tr_base, in ascending field index k at byte address tr_base + 4*k. Field k is read through ctx_rd_idx = k. The index map is: general registers 0–7, segment registers 8–13, flags 14, instruction pointer 15, then a stack selector and a stack pointer for each privilege level 0, 1 and 2 at 16–21, local table selector 22, page table base 23.
- R3: After the last save write and before any descriptor read, tr_sel is loaded with the requested selector.
- R4: The descriptor is read as two words, at gdt_base + 8*sel[15:3] and then 4 bytes higher. The first word is the new record base. In the second word, bits [3:0] are the type and bit 7 is the present flag. The entry is valid only if it is present and its type is 4'h9. On a valid entry, tr_base takes the first word.
- R5: On a valid descriptor, all 24 fields are read in ascending k from the new tr_base + 4*k, and each word is written to register index k through ctx_wr_en / ctx_wr_idx / ctx_wr_data.
- R6: done pulses for one cycle, in the cycle after the write of index 23. busy is high from the cycle after a request is accepted through the final restore cycle, and it is low in the done cycle. busy is high whenever mem_req is high.
- R7: On an invalid descriptor, fault pulses for one cycle. No register file write occurs, done does not pulse, tr_sel returns to its previous value and tr_base is unchanged. The current record still holds the context saved in that switch.
- R8: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata hold their values. An access completes only on a cycle where mem_ack is high.
- R9: A request raised while busy is ignored and does not affect that switch or start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Switch request, one cycle |
| sw_sel | input | SEL_W | Selector of the target task |
| gdt_base | input | ADDR_W | Byte base of the global descriptor table |
| busy | output | 1 | Switch in progress |
| done | output | 1 | Switch complete, resume pulse |
| fault | output | 1 | Target descriptor rejected, pulse |
| tr_sel | output | SEL_W | Task register selector |
| tr_base | output | ADDR_W | Task register record base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) / read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access acknowledge |
| ctx_rd_idx | output | IDX_W | Register file read index for saving |
| ctx_rd_data | input | DATA_W | Register file read data at ctx_rd_idx |
| ctx_wr_en | output | 1 | Register file write strobe |
| ctx_wr_idx | output | IDX_W | Register file write index |
| ctx_wr_data | output | DATA_W | Register file write data |

## Verification
Each memory access can be traced to the field counter or the phase that produced it. A wrong counter or phase therefore appears on the memory port at the very next completed access, as an address out of sequence or a read/write direction that does not match. An error in the task register appears later. It shows on tr_sel when the descriptor address is formed, and on tr_base when the restore addresses are formed. After the switch it shows as register file contents that differ from the target record. A faulty abort path appears in the cycle of the fault pulse, as a register write, a moved tr_base, or a done pulse.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_ISSUE,
    ST_SAVE_WAIT,
    ST_RETARGET,
    ST_DESC0_ISSUE,
    ST_DESC0_WAIT,
    ST_DESC1_ISSUE,
    ST_DESC1_WAIT,
    ST_REST_ISSUE,
    ST_REST_WAIT,
    ST_RESUME,
    ST_ABORT
  } tsw_state_e;

  // Fields in a task record: general, segment, flags, ip,
  // (selector, stack pointer) per privilege level, local table sel, page base.
  function automatic int field_count(input int n_gpr, input int n_seg, input int n_priv);
    return n_gpr + n_seg + 2 + 2 * n_priv + 2;
  endfunction

endpackage

// File: rtl/tsw_offset_rom.sv
module tsw_offset_rom #(
  parameter int NUM_FIELDS = 24,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] off
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_off
    if (g < NUM_FIELDS) begin : g_used
      assign table_q[g] = ADDR_W'(g * WORD_BYTES);
    end else begin : g_unused
      assign table_q[g] = '0;
    end
  end

  assign off = table_q[idx];

endmodule

// File: rtl/tsw_desc_check.sv
module tsw_desc_check #(
  parameter logic [3:0] TSS_TYPE = 4'h9
) (
  input  logic       present,
  input  logic [3:0] type_code,
  output logic       is_task_rec
);
  assign is_task_rec = present && (type_code == TSS_TYPE);
endmodule

// File: rtl/tsw_task_reg.sv
module tsw_task_reg #(
  parameter int              SEL_W    = 16,
  parameter int              ADDR_W   = 32,
  parameter logic [15:0]     RST_SEL  = 16'h0008,
  parameter logic [31:0]     RST_BASE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_sel,
  input  logic [SEL_W-1:0]  new_sel,
  input  logic              revert,
  input  logic              commit_base,
  input  logic [ADDR_W-1:0] new_base,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [ADDR_W-1:0] tr_base
);
  logic [SEL_W-1:0] prev_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_sel   <= SEL_W'(RST_SEL);
      prev_sel <= SEL_W'(RST_SEL);
      tr_base  <= ADDR_W'(RST_BASE);
    end else begin
      if (load_sel) begin
        prev_sel <= tr_sel;
        tr_sel   <= new_sel;
      end else if (revert) begin
        tr_sel <= prev_sel;
      end
      if (commit_base) begin
        tr_base <= new_base;
      end
    end
  end

  // R7: a rejected entry never moves the record base in the same cycle
  assert_no_commit_on_revert_R7: assert property (@(posedge clk) disable iff (rst)
    revert |=> $stable(tr_base));

endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tsw_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          SEL_W       = 16,
  parameter int          NUM_GPR     = 8,
  parameter int          NUM_SEG     = 6,
  parameter int          NUM_PRIV    = 3,
  parameter logic [3:0]  TSS_TYPE    = 4'h9,
  parameter logic [15:0] TR_RST_SEL  = 16'h0008,
  parameter logic [31:0] TR_RST_BASE = 32'h0000_1000,
  localparam int         NUM_FIELDS  = field_count(NUM_GPR, NUM_SEG, NUM_PRIV),
  localparam int         IDX_W       = $clog2(NUM_FIELDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_req,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic [ADDR_W-1:0] gdt_base,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [ADDR_W-1:0] tr_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [IDX_W-1:0]  ctx_rd_idx,
  input  logic [DATA_W-1:0] ctx_rd_data,
  output logic              ctx_wr_en,
  output logic [IDX_W-1:0]  ctx_wr_idx,
  output logic [DATA_W-1:0] ctx_wr_data
);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NUM_FIELDS - 1);
  localparam int               DESC_SHIFT = 3;

  tsw_state_e        state;
  logic [IDX_W-1:0]  cnt;
  logic [SEL_W-1:0]  pend_sel;
  logic [ADDR_W-1:0] desc_base;
  logic [ADDR_W-1:0] field_off;
  logic [ADDR_W-1:0] desc_addr;
  logic              desc_ok;
  logic              load_sel;
  logic              commit_base;
  logic              revert;
  logic              desc1_done;

  // ---------------------------------------------------------------
  // Field offset table and descriptor decode
  // ---------------------------------------------------------------
  tsw_offset_rom #(
    .NUM_FIELDS (NUM_FIELDS),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .WORD_BYTES (DATA_W / 8)
  ) u_off (
    .idx (cnt),
    .off (field_off)
  );

  tsw_desc_check #(
    .TSS_TYPE (TSS_TYPE)
  ) u_chk (
    .present     (mem_rdata[7]),
    .type_code   (mem_rdata[3:0]),
    .is_task_rec (desc_ok)
  );

  assign desc_addr = gdt_base
                   + ADDR_W'({pend_sel[SEL_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}});

  assign desc1_done  = (state == ST_DESC1_WAIT) && mem_ack;
  assign load_sel    = (state == ST_RETARGET);
  assign commit_base = desc1_done && desc_ok;
  assign revert      = desc1_done && !desc_ok;

  tsw_task_reg #(
    .SEL_W    (SEL_W),
    .ADDR_W   (ADDR_W),
    .RST_SEL  (TR_RST_SEL),
    .RST_BASE (TR_RST_BASE)
  ) u_tr (
    .clk         (clk),
    .rst         (rst),
    .load_sel    (load_sel),
    .new_sel     (pend_sel),
    .revert      (revert),
    .commit_base (commit_base),
    .new_base    (desc_base),
    .tr_sel      (tr_sel),
    .tr_base     (tr_base)
  );

  assign ctx_rd_idx = cnt;

  // ---------------------------------------------------------------
  // Sequencer
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      pend_sel    <= '0;
      desc_base   <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      ctx_wr_en   <= 1'b0;
      ctx_wr_idx  <= '0;
      ctx_wr_data <= '0;
    end else begin
      done      <= 1'b0;
      fault     <= 1'b0;
      ctx_wr_en <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sw_req) begin
            pend_sel <= sw_sel;
            cnt      <= '0;
            busy     <= 1'b1;
            state    <= ST_SAVE_ISSUE;
          end
        end
        ST_SAVE_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= tr_base + field_off;
          mem_wdata <= ctx_rd_data;
          state     <= ST_SAVE_WAIT;
        end
        ST_SAVE_WAIT: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (cnt == LAST_IDX) begin
              state <= ST_RETARGET;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_SAVE_ISSUE;
            end
          end
        end
        ST_RETARGET: begin
          state <= ST_DESC0_ISSUE;
        end
        ST_DESC0_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= desc_addr;
          state    <= ST_DESC0_WAIT;
        end
        ST_DESC0_WAIT: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            desc_base <= mem_rdata[ADDR_W-1:0];
            state     <= ST_DESC1_ISSUE;
          end
        end
        ST_DESC1_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= desc_addr + ADDR_W'(DATA_W / 8);
          state    <= ST_DESC1_WAIT;
        end
        ST_DESC1_WAIT: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            cnt     <= '0;
            state   <= desc_ok ? ST_REST_ISSUE : ST_ABORT;
          end
        end
        ST_REST_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= tr_base + field_off;
          state    <= ST_REST_WAIT;
        end
        ST_REST_WAIT: begin
          if (mem_ack) begin
            mem_req     <= 1'b0;
            ctx_wr_en   <= 1'b1;
            ctx_wr_idx  <= cnt;
            ctx_wr_data <= mem_rdata;
            if (cnt == LAST_IDX) begin
              state <= ST_RESUME;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_REST_ISSUE;
            end
          end
        end
        ST_RESUME: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        ST_ABORT: begin
          fault <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  // R8: a stalled access keeps every request field steady
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R6: memory traffic only inside a busy window
  assert_req_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R6: the resume pulse directly follows a register write
  assert_done_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ctx_wr_en));

  // R6 / R7: completion and abort are exclusive
  assert_end_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault}));

  // R7: no register write accompanies an abort
  assert_fault_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> !ctx_wr_en && !$past(ctx_wr_en));

  // R3: the descriptor is looked up with the task register already retargeted
  assert_retarget_first_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DESC0_ISSUE) |-> (tr_sel == pend_sel));

endmodule

// File: tb/task_switch_seq_tb.sv
module task_switch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF         = 24;
  localparam int IW         = 5;
  localparam logic [31:0] GDT   = 32'h0000_0800;
  localparam logic [31:0] RBASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_req = 1'b0;
  logic [15:0] sw_sel = '0;
  logic        busy, done, fault;
  logic [15:0] tr_sel;
  logic [31:0] tr_base;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [IW-1:0] ctx_rd_idx;
  logic [31:0] ctx_rd_data;
  logic        ctx_wr_en;
  logic [IW-1:0] ctx_wr_idx;
  logic [31:0] ctx_wr_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  task_switch_seq u_dut (
    .clk, .rst, .sw_req, .sw_sel, .gdt_base (GDT),
    .busy, .done, .fault, .tr_sel, .tr_base,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .ctx_rd_idx, .ctx_rd_data, .ctx_wr_en, .ctx_wr_idx, .ctx_wr_data
  );

  // memory and register file models
  logic [31:0] mem  [4096];
  logic [31:0] regs [NF];
  assign ctx_rd_data = regs[ctx_rd_idx];

  int  tests = 0, fails = 0;
  int  lat = 0;
  bit  pending = 0;
  bit  finished = 0;

  always @(negedge clk) begin
    if (!mem_req) begin
      pending = 0;
      mem_ack = 0;
    end else begin
      if (!pending) begin
        pending = 1;
        lat = int'($urandom % 4);
      end
      if (lat == 0) begin
        mem_ack   = 1;
        mem_rdata = mem[mem_addr[13:2]];
        pending   = 0;
      end else begin
        lat--;
        mem_ack = 0;
      end
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    if (ctx_wr_en) regs[ctx_wr_idx] <= ctx_wr_data;
  end

  // access sequence monitor
  logic [31:0] exp_addr [64];
  bit          exp_we   [64];
  int          exp_len = 0, pos = 0, seq_err = 0, sel_err = 0;
  int          stall_err = 0, busy_err = 0, done_err = 0;
  logic [15:0] exp_sel = '0;
  bit          p_stall = 0, p_we = 0, p_last = 0;
  logic [31:0] p_addr = '0, p_wdata = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (p_stall && !(mem_req && mem_addr == p_addr && mem_we == p_we
                       && mem_wdata == p_wdata)) stall_err++;
      if (mem_req && !busy) busy_err++;
      if (done && !p_last) done_err++;
      if (mem_req && mem_ack) begin
        if (pos >= exp_len || mem_addr != exp_addr[pos] || mem_we != exp_we[pos])
          seq_err++;
        if (pos == NF && tr_sel != exp_sel) sel_err++;
        pos++;
      end
    end
    p_stall = mem_req && !mem_ack;
    p_addr  = mem_addr;
    p_we    = mem_we;
    p_wdata = mem_wdata;
    p_last  = ctx_wr_en && (ctx_wr_idx == IW'(NF - 1));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] base_of(input int idx);
    return RBASE + 32'((idx - 1) * 256);
  endfunction

  logic [15:0] cur_sel;
  logic [31:0] cur_base;

  task automatic do_switch(input int idx, input bit good, input bit poke);
    logic [31:0] saved [NF];
    logic [31:0] want  [NF];
    logic [31:0] nb;
    logic [15:0] sel;
    bit saw_done, saw_fault;
    int n, mism;
    sel = {13'(idx), 3'($urandom % 8)};
    nb  = base_of(idx);
    for (int k = 0; k < NF; k++) saved[k] = regs[k];
    for (int k = 0; k < NF; k++)
      want[k] = (nb == cur_base) ? saved[k] : mem[(nb[13:2]) + 12'(k)];
    for (int k = 0; k < NF; k++) begin
      exp_addr[k] = cur_base + 32'(4 * k);
      exp_we[k]   = 1;
    end
    exp_addr[NF]   = GDT + 32'(8 * idx);  exp_we[NF]   = 0;
    exp_addr[NF+1] = GDT + 32'(8 * idx + 4); exp_we[NF+1] = 0;
    exp_len = NF + 2;
    if (good) begin
      for (int k = 0; k < NF; k++) begin
        exp_addr[NF+2+k] = nb + 32'(4 * k);
        exp_we[NF+2+k]   = 0;
      end
      exp_len = 2 * NF + 2;
    end
    exp_sel = sel;
    pos = 0; seq_err = 0; sel_err = 0; stall_err = 0; busy_err = 0; done_err = 0;
    sw_sel = sel; sw_req = 1;
    @(negedge clk);
    sw_req = 0;
    chk(busy == 1'b1, "R6", "busy after accept", 32'(busy), 32'd1);
    saw_done = 0; saw_fault = 0; n = 0;
    while (!saw_done && !saw_fault && n < 3000) begin
      if (poke && n == 15) begin
        sw_sel = 16'h00F8; sw_req = 1;
      end else sw_req = 0;
      @(negedge clk);
      n++;
      if (done) begin
        saw_done = 1;
        chk(busy == 1'b0, "R6", "busy low in done cycle", 32'(busy), 32'd0);
      end
      if (fault) saw_fault = 1;
    end
    sw_req = 0;
    chk(saw_done == good, "R5", "done seen", 32'(saw_done), 32'(good));
    chk(saw_fault == !good, "R7", "fault seen", 32'(saw_fault), 32'(!good));
    chk(seq_err == 0 && pos == exp_len, "R2", "access order errors", 32'(seq_err), 32'd0);
    chk(sel_err == 0, "R3", "tr_sel at descriptor read", 32'(sel_err), 32'd0);
    chk(stall_err == 0, "R8", "stall stability errors", 32'(stall_err), 32'd0);
    chk(busy_err == 0 && done_err == 0, "R6", "busy/done timing errors",
        32'(busy_err + done_err), 32'd0);
    mism = 0;
    for (int k = 0; k < NF; k++)
      if (nb != cur_base || !good)
        if (mem[cur_base[13:2] + 12'(k)] != saved[k]) mism++;
    chk(mism == 0, "R2", "saved record mismatches", 32'(mism), 32'd0);
    mism = 0;
    for (int k = 0; k < NF; k++)
      if (regs[k] != (good ? want[k] : saved[k])) mism++;
    chk(mism == 0, good ? "R5" : "R7", "register file mismatches", 32'(mism), 32'd0);
    if (good) begin
      cur_sel = sel; cur_base = nb;
    end
    chk(tr_sel == cur_sel, good ? "R4" : "R7", "tr_sel", 32'(tr_sel), 32'(cur_sel));
    chk(tr_base == cur_base, "R4", "tr_base", tr_base, cur_base);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req, "R9", "no switch started by request while busy",
          32'(busy), 32'd0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        finished = 1;
        fails++; tests++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    for (int i = 1; i <= 10; i++) begin
      mem[(GDT[13:2]) + 12'(2 * i)]     = base_of(i);
      mem[(GDT[13:2]) + 12'(2 * i + 1)] = (i == 9)  ? 32'h0000_0081 :
                                          (i == 10) ? 32'h0000_0009 : 32'h0000_0089;
    end
    for (int k = 0; k < NF; k++) regs[k] = $urandom;
    cur_sel = 16'h0008; cur_base = RBASE;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req && !ctx_wr_en, "R1", "control outputs",
        32'({busy, done, fault, mem_req, ctx_wr_en}), 32'd0);
    chk(tr_sel == 16'h0008, "R1", "reset tr_sel", 32'(tr_sel), 32'h8);
    chk(tr_base == RBASE, "R1", "reset tr_base", tr_base, RBASE);
    do_switch(2, 1, 0);   // R2 R3 R4 R5 basic
    do_switch(9, 0, 0);   // R7 wrong type
    do_switch(10, 0, 0);  // R7 not present
    do_switch(2, 1, 0);   // switch to self
    do_switch(5, 1, 1);   // R9 request while busy
    for (int t = 0; t < 20; t++) begin
      int i;
      i = 1 + int'($urandom % 10);
      do_switch(i, i < 9, (t % 5) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule